// File: doc/BRIEF.md
# Parallel Host Port for a Graphic Display Controller

This block is the host side of a small graphic display controller. A processor reaches it over an asynchronous 6800-style parallel bus: chip select (active low), a read/write level, an enable strobe and a data/command level. The same eight data lines carry command bytes, display data and a status byte. Which one a transfer carries depends on the data/command and read/write levels. The bidirectional data bus is split into an input byte, an output byte and an output enable, so the pad ring can build the tri-state buffer.

The block synchronises the enable strobe and chip select into its own clock. It acts on a transfer at the falling edge of the strobe. Command bytes move a page/column address pointer or switch a display-on flag. Data writes go into an internal display memory of 8 pages by 128 column bytes. Data reads go through a one-byte prefetch latch. Because of that latch, the first read after the address is set returns a dummy byte, and real data starts with the next read. The column pointer steps after every data read and every data write, and wraps around at the end of the row.

Top module: `lcd_host_port`

## Requirements
- R1: After reset the column and page pointers are 0, the display-on flag is clear, the prefetch latch holds 0x00, the status byte reads 0x00 once the start-up window has passed, and the output enable is low while the bus is idle.
- R2: Status bit 7 (busy) reads 1 during reset and for INIT_CYCLES clock cycles after reset is released, then reads 0 and stays 0.
- R3: The output enable is high exactly while chip select is low, read/write is high (read) and the enable strobe is high. At all other times it is low.
- R4: A transfer with read/write low and data/command high stores the bus byte in display memory at the current page and column, then advances the column by one.
- R5: Command bytes 0x00-0x0F load column bits 3:0 from the low nibble of the command. Command bytes 0x10-0x17 load column bits 6:4 from command bits 2:0.
- R6: Command bytes 0xB0-0xB7 load the page pointer from command bits 2:0.
- R7: A data read returns the byte held in the prefetch latch. It then loads the latch from the current address and advances the column by one, dummy reads included. Any address command (R5, R6) and any data write clear the latch to 0x00. So the first read after either returns 0x00 and the second read returns the byte at the address that was set.
- R8: The column pointer wraps from 127 to 0 on both reads and writes, and the page pointer is not changed by the wrap.
- R9: Command 0xAF sets the display-on flag and 0xAE clears it. The flag reads back as status bit 6, and status bits 5:0 are always 0. A read with data/command low returns the status byte.
- R10: A strobe falling edge that occurs while chip select is high has no effect on memory, pointers or flags.
- R11: A reset applied in mid-operation returns pointers, flags and latch to their reset values. The display memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low (asynchronous) |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_en | input | 1 | Enable strobe; the transfer is taken at its falling edge |
| bus_dc | input | 1 | 1 = display data, 0 = command/status |
| bus_din | input | 8 | Byte from the host |
| bus_dout | output | 8 | Byte to the host (prefetch latch or status) |
| bus_oe | output | 1 | Output enable for the data bus pads |

## Verification
Assertions run on every cycle. They check that the column pointer steps by exactly one or wraps from 127 to 0, that the page pointer stays put during column steps, that a synchronised strobe lasts a single cycle, that an address command leaves the prefetch latch at zero, and that busy never comes back once it has dropped. Only the bench scenarios can show the byte-level results. These are the dummy-then-valid read order, that written bytes land at the page and column the commands selected, that the row wraps inside the same page, that strobes without chip select are ignored, and that memory survives a mid-operation reset while the pointers and flags do not.

// File: rtl/lcd_port_pkg.sv
// Shared types for the display controller host port.
// Assumes a 6800-style bus: the rw level selects read/write, the dc level selects data/command.
package lcd_port_pkg;
    // Transfer kind decoded from {rw, dc}.
    typedef enum logic [1:0] {
        CYC_CMD_WR  = 2'b00,
        CYC_DATA_WR = 2'b01,
        CYC_STAT_RD = 2'b10,
        CYC_DATA_RD = 2'b11
    } cyc_e;

    localparam logic [7:0] CMD_DISP_OFF = 8'hAE;
    localparam logic [7:0] CMD_DISP_ON  = 8'hAF;
endpackage

// File: rtl/lcd_strobe_sync.sv
// Brings the asynchronous enable strobe and chip select into the clock domain
// through two-flop synchronisers, then emits a one-cycle pulse at the falling
// edge of the strobe, qualified by chip select being low.
// Assumes the host keeps chip select low for a few clocks around the strobe.
module lcd_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_en,
    input  logic bus_cs_n,
    output logic strobe
);
    logic en_meta, en_sync, en_last;
    logic cs_meta, cs_sync;

    // Synchroniser chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_meta <= 1'b0;
            en_sync <= 1'b0;
            en_last <= 1'b0;
            cs_meta <= 1'b1;
            cs_sync <= 1'b1;
        end else begin
            en_meta <= bus_en;
            en_sync <= en_meta;
            en_last <= en_sync;
            cs_meta <= bus_cs_n;
            cs_sync <= cs_meta;
        end
    end

    assign strobe = en_last & ~en_sync & ~cs_sync;

    // R10: a qualified strobe is a single-cycle pulse.
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/lcd_addr_ptr.sv
// Page and column address pointer. Commands load the nibbles of the column or
// the page; each data access advances the column, wrapping at the last column.
// Assumes COLS is a power of two of at least 32, so the column is above 4 bits wide.
module lcd_addr_ptr #(
    parameter int COLS  = 128,
    parameter int PAGES = 8,
    localparam int COL_W  = $clog2(COLS),
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              ld_page,
    input  logic [3:0]        nib,
    input  logic              inc,
    output logic [COL_W-1:0]  col,
    output logic [PAGE_W-1:0] page
);
    localparam logic [COL_W-1:0] LAST = COL_W'(COLS - 1);

    // Column pointer: nibble loads take priority over the auto increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col <= '0;
        else if (ld_lo)
            col[3:0] <= nib;
        else if (ld_hi)
            col[COL_W-1:4] <= nib[COL_W-5:0];
        else if (inc)
            col <= (col == LAST) ? '0 : col + COL_W'(1);
    end

    // Page pointer: changes only on a page command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page <= '0;
        else if (ld_page)
            page <= nib[PAGE_W-1:0];
    end

    // R4: an access away from the last column moves exactly one step.
    a_r4_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld_lo && !ld_hi && col != LAST) |=> col == COL_W'($past(col) + COL_W'(1)));
    // R8: an access on the last column wraps to 0.
    a_r8_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld_lo && !ld_hi && col == LAST) |=> col == '0);
    // R8: column stepping never disturbs the page.
    a_r8_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld_page) |=> page == $past(page));
endmodule

// File: rtl/lcd_gram.sv
// Display memory: a single-port byte array with synchronous write and a
// registered read. Only the host port uses the port, so there is no arbitration.
// Contents are not cleared by reset.
module lcd_gram #(
    parameter int DEPTH = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout
);
    logic [7:0] mem [DEPTH];

    // One access per cycle: a write, or a read into the output register.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= din;
        else if (re)
            dout <= mem[addr];
    end
endmodule

// File: rtl/lcd_host_port.sv
// Host-side parallel port of the display controller. Decodes each transfer at
// the synchronised strobe falling edge, updates pointers and flags, writes or
// prefetches display memory, and drives the status byte or prefetch latch.
// Assumes rw, dc and the data byte stay stable from strobe rise until
// several clocks after strobe fall (covers the synchroniser latency).
module lcd_host_port
    import lcd_port_pkg::*;
#(
    parameter int COLS        = 128,
    parameter int PAGES       = 8,
    parameter int INIT_CYCLES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cs_n,
    input  logic       bus_rw,
    input  logic       bus_en,
    input  logic       bus_dc,
    input  logic [7:0] bus_din,
    output logic [7:0] bus_dout,
    output logic       bus_oe
);
    localparam int COL_W  = $clog2(COLS);
    localparam int PAGE_W = $clog2(PAGES);
    localparam int CNT_W  = $clog2(INIT_CYCLES + 1);

    logic              strobe;
    cyc_e              cyc;
    logic              cmd_wr, data_wr, data_rd;
    logic              ld_lo, ld_hi, ld_page, addr_cmd;
    logic [COL_W-1:0]  col;
    logic [PAGE_W-1:0] page;
    logic [7:0]        gram_q;
    logic [7:0]        rd_latch;
    logic              rd_pend;
    logic              disp_on;
    logic [CNT_W-1:0]  init_cnt;
    logic              busy;

    lcd_strobe_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_cs_n (bus_cs_n),
        .strobe   (strobe)
    );

    // Transfer decode, valid only in the strobe cycle.
    always_comb begin
        cyc      = cyc_e'({bus_rw, bus_dc});
        cmd_wr   = strobe && (cyc == CYC_CMD_WR);
        data_wr  = strobe && (cyc == CYC_DATA_WR);
        data_rd  = strobe && (cyc == CYC_DATA_RD);
        ld_lo    = cmd_wr && (bus_din[7:4] == 4'h0);
        ld_hi    = cmd_wr && (bus_din[7:4] == 4'h1) && (int'(bus_din[3:0]) < (COLS / 16));
        ld_page  = cmd_wr && (bus_din[7:4] == 4'hB) && (int'(bus_din[3:0]) < PAGES);
        addr_cmd = ld_lo || ld_hi || ld_page;
    end

    lcd_addr_ptr #(.COLS(COLS), .PAGES(PAGES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ld_page (ld_page),
        .nib     (bus_din[3:0]),
        .inc     (data_wr || data_rd),
        .col     (col),
        .page    (page)
    );

    lcd_gram #(.DEPTH(COLS * PAGES)) u_gram (
        .clk  (clk),
        .we   (data_wr),
        .re   (data_rd),
        .addr ({page, col}),
        .din  (bus_din),
        .dout (gram_q)
    );

    // Prefetch latch: filled one cycle after a read, cleared when the address or data moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend  <= 1'b0;
            rd_latch <= 8'h00;
        end else begin
            rd_pend <= data_rd;
            if (rd_pend)
                rd_latch <= gram_q;
            else if (addr_cmd || data_wr)
                rd_latch <= 8'h00;
        end
    end

    // Display-on flag driven by its on/off commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            disp_on <= 1'b0;
        else if (cmd_wr && bus_din == CMD_DISP_ON)
            disp_on <= 1'b1;
        else if (cmd_wr && bus_din == CMD_DISP_OFF)
            disp_on <= 1'b0;
    end

    // Start-up busy window counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_cnt <= CNT_W'(INIT_CYCLES);
        else if (init_cnt != '0)
            init_cnt <= init_cnt - CNT_W'(1);
    end

    assign busy = (init_cnt != '0);

    // Bus output: driven straight from the pins so it follows the strobe without lag.
    assign bus_oe   = ~bus_cs_n & bus_rw & bus_en;
    assign bus_dout = bus_dc ? rd_latch : {busy, disp_on, 6'b000000};

    // R7: an address command leaves the prefetch latch at zero.
    a_r7_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_cmd && !rd_pend) |=> rd_latch == 8'h00);
    // R2: once busy has dropped it stays low.
    a_r2_busy_once: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);
endmodule

// File: tb/tb_lcd_host_port.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected bytes, the monitor pops and compares.
module tb_lcd_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1, bus_rw = 1'b0, bus_en = 1'b0, bus_dc = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_oe;

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    int done_cnt = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    lcd_host_port dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rw(bus_rw),
        .bus_en(bus_en), .bus_dc(bus_dc), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_oe(bus_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected byte per request and compares with the bus.
    always @(negedge clk) begin
        if (req_cnt != done_cnt) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_dout == e, t, bus_dout, e);
            check(bus_oe == 1'b1, {t, " R3 oe"}, bus_oe, 1);
            done_cnt++;
        end
    end

    task automatic cyc_wait(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic dc, input logic [7:0] b, input logic cs_n = 1'b0);
        bus_cs_n = cs_n; bus_rw = 1'b0; bus_dc = dc; bus_din = b;
        cyc_wait(2);
        bus_en = 1'b1;
        cyc_wait(4);
        bus_en = 1'b0;
        cyc_wait(6);
        bus_cs_n = 1'b1;
        cyc_wait(2);
    endtask

    task automatic bus_read(input logic dc, input logic [7:0] e, input string tag);
        bus_cs_n = 1'b0; bus_rw = 1'b1; bus_dc = dc;
        cyc_wait(2);
        bus_en = 1'b1;
        cyc_wait(6);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_cnt++;
        wait (done_cnt == req_cnt);
        cyc_wait(1);
        bus_en = 1'b0;
        cyc_wait(6);
        bus_cs_n = 1'b1;
        cyc_wait(2);
    endtask

    task automatic set_addr(input logic [7:0] pg, input logic [7:0] c);
        bus_write(1'b0, 8'hB0 | pg);
        bus_write(1'b0, {4'h0, c[3:0]});
        bus_write(1'b0, {4'h1, c[7:4]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R2: busy during reset and just after release, seen through a status read.
        cyc_wait(5);
        bus_cs_n = 1'b0; bus_rw = 1'b1; bus_dc = 1'b0; bus_en = 1'b1;
        cyc_wait(1);
        check(bus_dout == 8'h80, "R2 busy in reset", bus_dout, 8'h80);
        rst_n = 1'b1;
        cyc_wait(3);
        check(bus_dout == 8'h80, "R2 busy after release", bus_dout, 8'h80);
        bus_en = 1'b0;
        cyc_wait(6);
        bus_cs_n = 1'b1;
        cyc_wait(40);
        check(bus_oe == 1'b0, "R1 idle oe", bus_oe, 0);
        bus_read(1'b0, 8'h00, "R1 R2 status after init");
        bus_read(1'b1, 8'h00, "R1 dummy after reset");

        // R3: no drive on writes or without chip select.
        bus_cs_n = 1'b0; bus_rw = 1'b0; bus_en = 1'b1; cyc_wait(2);
        check(bus_oe == 1'b0, "R3 oe in write", bus_oe, 0);
        bus_cs_n = 1'b1; bus_rw = 1'b1; cyc_wait(2);
        check(bus_oe == 1'b0, "R3 oe no cs", bus_oe, 0);
        bus_en = 1'b0; cyc_wait(6);

        // R9: display-on flag in status bit 6.
        bus_write(1'b0, 8'hAF);
        bus_read(1'b0, 8'h40, "R9 display on");
        bus_write(1'b0, 8'hAE);
        bus_read(1'b0, 8'h00, "R9 display off");

        // R4 R5 R6: writes at page 2 column 0x15, then R7 dummy-then-data reads.
        set_addr(8'd2, 8'h15);
        bus_write(1'b1, 8'hAA);
        bus_write(1'b1, 8'hBB);
        bus_write(1'b1, 8'hCC);
        set_addr(8'd2, 8'h15);
        bus_read(1'b1, 8'h00, "R7 dummy read");
        bus_read(1'b1, 8'hAA, "R4 R5 R6 first byte");
        bus_read(1'b1, 8'hBB, "R4 second byte");
        bus_read(1'b1, 8'hCC, "R4 third byte");

        // R8: wrap at the row end keeps the page.
        set_addr(8'd6, 8'h00);
        bus_write(1'b1, 8'h99);
        set_addr(8'd5, 8'h7E);
        bus_write(1'b1, 8'h11);
        bus_write(1'b1, 8'h22);
        bus_write(1'b1, 8'h33);
        set_addr(8'd5, 8'h7E);
        bus_read(1'b1, 8'h00, "R8 dummy");
        bus_read(1'b1, 8'h11, "R8 col 126");
        bus_read(1'b1, 8'h22, "R8 col 127");
        bus_read(1'b1, 8'h33, "R8 wrapped col 0 same page");

        // R7: a data write clears the latch.
        bus_write(1'b1, 8'h44);
        bus_read(1'b1, 8'h00, "R7 latch cleared by write");

        // R10: strobes without chip select do nothing.
        set_addr(8'd2, 8'h15);
        bus_write(1'b1, 8'hEE, 1'b1);
        bus_write(1'b0, 8'hAF, 1'b1);
        bus_write(1'b0, 8'hB7, 1'b1);
        bus_read(1'b0, 8'h00, "R10 flag unchanged");
        bus_read(1'b1, 8'h00, "R10 dummy");
        bus_read(1'b1, 8'hAA, "R10 memory and address unchanged");

        // R11: mid-operation reset clears pointers and flags, keeps memory.
        set_addr(8'd0, 8'h00);
        bus_write(1'b1, 8'h77);
        bus_write(1'b0, 8'hAF);
        set_addr(8'd3, 8'h40);
        bus_read(1'b1, 8'h00, "R11 pre-reset dummy");
        rst_n = 1'b0;
        cyc_wait(3);
        rst_n = 1'b1;
        cyc_wait(40);
        bus_read(1'b0, 8'h00, "R11 flag cleared");
        bus_read(1'b1, 8'h00, "R11 latch cleared");
        bus_read(1'b1, 8'h77, "R11 pointer at 0 memory kept");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule